// File: doc/BRIEF.md
# Memory Base Address Register with Address Decode

This block holds one 32-bit memory base register for a bus target and decides, for each address phase on the bus, whether the target claims the transaction. Configuration software programs the base through a small register port with byte enables. To learn the region size, software writes all ones and reads the value back: the bits below the region size are fixed at zero and never take a write. The four low bits always read as 0000, which marks a non-prefetchable memory region that may sit anywhere in the 32-bit space.

The claim output drives the device-select logic of the target. It is combinational on the address-phase inputs. It is raised only when four conditions all hold: the command is a memory command, the global memory-space enable from the command register is set, the upper address bits match the programmed base, and the base is not zero. A base of zero means the register is switched off. No address is claimed, not even one inside the window that starts at zero, because low addresses belong to resources local to the host. A switched-off register still answers configuration reads.

Top module: `pcibar_mem_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, the stored base is zero. A configuration read issued right after reset returns 0x00000000, and no address is claimed.
- R2: Readback bits [3:0] are always 0000. Base bits below the region size (bits [11:0] for the default 4 KiB) read as zero even after all ones is written, so writing 0xFFFFFFFF reads back 0xFFFFF000.
- R3: A write changes only the base bits in byte lanes whose enable is 1. Enable bit k covers data bits [8k+7:8k].
- R4: `bar_hit` is 1 in the same cycle as the address phase when `bus_addr_valid` is 1, the command is a memory command, `mem_space_en` is 1, the base is nonzero and `bus_addr[31:12]` equals the base. Offsets 0x000 through 0xFFF of the window are claimed.
- R5: When `mem_space_en` is 0, `bar_hit` stays 0 for every address and command.
- R6: When the stored base is zero, `bar_hit` stays 0, including for addresses 0x00000000 through 0x00000FFF.
- R7: Configuration reads work whatever the values of `mem_space_en` and the base: they return the stored base with `mem_space_en` at 0, and they return zero when the base is zero.
- R8: Only command codes 0110, 0111, 1100, 1110 and 1111 (memory read, memory write, read multiple, read line, write and invalidate) can produce a hit. All other codes, such as 0010 (I/O read) and 1010 (configuration read), never do.
- R9: An address one word below the window (base minus 4) or at the first byte above it (base plus size) is not claimed.
- R10: `cfg_rdata` is registered. It takes the readback value at the clock edge where `cfg_re` is 1 and keeps that value while `cfg_re` is 0.
- R11: With `cfg_we` at 0, the base does not change, whatever the data and byte enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe for this register |
| cfg_re | input | 1 | Configuration read strobe for this register |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered readback value |
| mem_space_en | input | 1 | Global memory-space enable from the command register |
| bus_addr_valid | input | 1 | Address phase is present |
| bus_cmd | input | 4 | Bus command code of the address phase |
| bus_addr | input | 32 | Address of the address phase |
| bar_hit | output | 1 | Combinational claim that drives device select |

## Verification
The hardest case is the zero-base window. Every other hit condition holds there: the memory-space enable is set, a memory command is presented, and the address matches a base of zero bit for bit. Only the explicit zero check keeps the block from claiming the address. The stimulus reaches this case by first programming a nonzero base and proving that a hit occurs. It then writes the base back to zero with all lanes enabled and presents addresses 0x0 and 0xFFC with the enable still set. Byte-lane isolation is exercised by writing partial lanes over a known pattern and reading back the merged result.

// File: rtl/pcibar_pkg.sv
package pcibar_pkg;
  // Fixed low readback field: memory space, 32-bit locatable, not prefetchable
  localparam logic [3:0] BAR_TYPE_BITS = 4'b0000;

  // Memory-class command codes that may be claimed
  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR      = 4'b0111;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
  localparam logic [3:0] CMD_MEM_WR_INV  = 4'b1111;

  function automatic logic is_mem_cmd(input logic [3:0] code);
    case (code)
      CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RD_MULT,
      CMD_MEM_RD_LINE, CMD_MEM_WR_INV: return 1'b1;
      default:                         return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pcibar_basereg.sv
// Writable base field. Only bits at or above the region size exist.
module pcibar_basereg #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_LOG2 = 12,
  localparam int BASE_W   = ADDR_W - SIZE_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BASE_W-1:0] bit_en,
  input  logic [BASE_W-1:0] wdata,
  output logic [BASE_W-1:0] base
);
  logic [BASE_W-1:0] base_q;

  generate
    for (genvar b = 0; b < BASE_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          base_q[b] <= 1'b0;
        else if (we && bit_en[b])
          base_q[b] <= wdata[b];
      end
    end
  endgenerate

  assign base = base_q;
endmodule

// File: rtl/pcibar_match.sv
// Address-phase compare. Combinational so the claim is ready in the address phase.
module pcibar_match #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_LOG2 = 12,
  localparam int BASE_W   = ADDR_W - SIZE_LOG2
) (
  input  logic [BASE_W-1:0] base,
  input  logic [BASE_W-1:0] addr_hi,
  input  logic [3:0]        cmd,
  input  logic              valid,
  input  logic              mse,
  output logic              hit
);
  import pcibar_pkg::*;

  logic base_live;
  logic addr_eq;

  always_comb begin
    base_live = |base;          // zero base means switched off
    addr_eq   = (addr_hi == base);
    hit       = valid && mse && is_mem_cmd(cmd) && base_live && addr_eq;
  end
endmodule

// File: rtl/pcibar_rdport.sv
// Registered configuration readback.
module pcibar_rdport #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_LOG2 = 12,
  localparam int BASE_W   = ADDR_W - SIZE_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  logic [BASE_W-1:0] base,
  output logic [ADDR_W-1:0] rdata
);
  import pcibar_pkg::*;

  logic [ADDR_W-1:0] view;
  logic [ADDR_W-1:0] rdata_q;

  always_comb begin
    view = {base, {SIZE_LOG2{1'b0}}};
    view[3:0] = BAR_TYPE_BITS;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (re)
      rdata_q <= view;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/pcibar_mem_decoder.sv
module pcibar_mem_decoder #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_LOG2 = 12,
  localparam int BASE_W   = ADDR_W - SIZE_LOG2,
  localparam int LANES    = ADDR_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [LANES-1:0]  cfg_be,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              mem_space_en,
  input  logic              bus_addr_valid,
  input  logic [3:0]        bus_cmd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bar_hit
);
  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] bit_en;

  // Spread byte enables over the writable bits only
  generate
    for (genvar i = 0; i < BASE_W; i++) begin : g_lane
      assign bit_en[i] = cfg_be[(i + SIZE_LOG2) / 8];
    end
  endgenerate

  pcibar_basereg #(.ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2)) u_base (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .bit_en (bit_en),
    .wdata  (cfg_wdata[ADDR_W-1:SIZE_LOG2]),
    .base   (base_q)
  );

  pcibar_match #(.ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2)) u_match (
    .base    (base_q),
    .addr_hi (bus_addr[ADDR_W-1:SIZE_LOG2]),
    .cmd     (bus_cmd),
    .valid   (bus_addr_valid),
    .mse     (mem_space_en),
    .hit     (bar_hit)
  );

  pcibar_rdport #(.ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .re    (cfg_re),
    .base  (base_q),
    .rdata (cfg_rdata)
  );
endmodule

// File: rtl/pcibar_mem_decoder_chk.sv
module pcibar_mem_decoder_chk #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_LOG2 = 12,
  localparam int BASE_W   = ADDR_W - SIZE_LOG2
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_rdata,
  input logic              mem_space_en,
  input logic              bus_addr_valid,
  input logic [3:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bar_hit,
  input logic [BASE_W-1:0] base
);
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (base == '0));  // R1
  AST_TYPE_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[3:0] == 4'b0000);  // R2
  AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    bar_hit |-> (bus_addr_valid && bus_addr[ADDR_W-1:SIZE_LOG2] == base));  // R4
  AST_HIT_NEEDS_MSE: assert property (@(posedge clk) disable iff (rst)
    bar_hit |-> mem_space_en);  // R5
  AST_HIT_NEEDS_BASE: assert property (@(posedge clk) disable iff (rst)
    bar_hit |-> (base != '0));  // R6
  AST_HIT_MEM_CMD: assert property (@(posedge clk) disable iff (rst)
    bar_hit |-> (bus_cmd == 4'b0110 || bus_cmd == 4'b0111 || bus_cmd == 4'b1100 ||
                 bus_cmd == 4'b1110 || bus_cmd == 4'b1111));  // R8
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(base));  // R11
endmodule

bind pcibar_mem_decoder pcibar_mem_decoder_chk #(.ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_we         (cfg_we),
  .cfg_rdata      (cfg_rdata),
  .mem_space_en   (mem_space_en),
  .bus_addr_valid (bus_addr_valid),
  .bus_cmd        (bus_cmd),
  .bus_addr       (bus_addr),
  .bar_hit        (bar_hit),
  .base           (base_q)
);

// File: tb/tb_pcibar_mem_decoder.sv
`timescale 1ns/1ps
module tb_pcibar_mem_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_re = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_space_en = 1'b0;
  logic        bus_addr_valid = 1'b0;
  logic [3:0]  bus_cmd = 4'h0;
  logic [31:0] bus_addr = '0;
  logic        bar_hit;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pcibar_mem_decoder dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic cfg_read(output logic [31:0] d);
    @(negedge clk); cfg_re = 1'b1;
    @(posedge clk); #1 d = cfg_rdata;
    @(negedge clk); cfg_re = 1'b0;
  endtask

  task automatic probe(input logic [3:0] cmd, input logic [31:0] a, input logic v,
                       input string req, input logic exp);
    @(negedge clk); bus_addr_valid = v; bus_cmd = cmd; bus_addr = a;
    #1 chk(req, {31'b0, bar_hit}, {31'b0, exp});
    @(negedge clk); bus_addr_valid = 1'b0;
  endtask

  function automatic logic mem_code(input logic [3:0] c);
    return c == 4'b0110 || c == 4'b0111 || c == 4'b1100 || c == 4'b1110 || c == 4'b1111;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    cfg_read(d); chk("R1 readback after reset", d, 32'h0);
    mem_space_en = 1'b1;
    probe(4'b0110, 32'h0, 1'b1, "R1 no hit after reset", 1'b0);
    mem_space_en = 1'b0;
  endtask

  task automatic t_sizing();
    logic [31:0] d;
    cfg_write(4'hF, 32'hFFFF_FFFF);
    cfg_read(d); chk("R2 sizing probe", d, 32'hFFFF_F000);
  endtask

  task automatic t_byte_lanes();
    logic [31:0] d;
    cfg_write(4'hF, 32'h0);
    cfg_write(4'b0100, 32'h1234_5678);
    cfg_read(d); chk("R3 lane2 only", d, 32'h0034_0000);
    cfg_write(4'b1000, 32'hABCD_EF01);
    cfg_read(d); chk("R3 lane3 merge", d, 32'hAB34_0000);
    cfg_write(4'b0011, 32'hFFFF_FFFF);
    cfg_read(d); chk("R3 low lanes", d, 32'hAB34_F000);
  endtask

  task automatic t_read_timing();
    logic [31:0] d;
    cfg_write(4'hF, 32'h5000_0000);
    #1 chk("R10 holds without read", cfg_rdata, 32'hAB34_F000);
    @(negedge clk); cfg_re = 1'b1;
    #1 chk("R10 old value before edge", cfg_rdata, 32'hAB34_F000);
    @(posedge clk); #1 d = cfg_rdata;
    chk("R10 updated after edge", d, 32'h5000_0000);
    @(negedge clk); cfg_re = 1'b0;
  endtask

  task automatic t_window();
    cfg_write(4'hF, 32'h8000_0000);
    mem_space_en = 1'b1;
    probe(4'b0110, 32'h8000_0000, 1'b1, "R4 first byte", 1'b1);
    probe(4'b0111, 32'h8000_0FFC, 1'b1, "R4 last word", 1'b1);
    probe(4'b0110, 32'h8000_0010, 1'b0, "R4 no valid", 1'b0);
    probe(4'b0110, 32'h7FFF_FFFC, 1'b1, "R9 below window", 1'b0);
    probe(4'b0110, 32'h8000_1000, 1'b1, "R9 above window", 1'b0);
  endtask

  task automatic t_cmds();
    for (int c = 0; c < 16; c++)
      probe(c[3:0], 32'h8000_0040, 1'b1, $sformatf("R8 cmd %b", c[3:0]), mem_code(c[3:0]));
  endtask

  task automatic t_mse_off();
    logic [31:0] d;
    mem_space_en = 1'b0;
    probe(4'b0110, 32'h8000_0000, 1'b1, "R5 mse off read", 1'b0);
    probe(4'b1111, 32'h8000_0800, 1'b1, "R5 mse off wr-inv", 1'b0);
    cfg_read(d); chk("R7 read with mse off", d, 32'h8000_0000);
  endtask

  task automatic t_zero_base();
    logic [31:0] d;
    cfg_write(4'hF, 32'h0000_0000);
    mem_space_en = 1'b1;
    probe(4'b0110, 32'h0000_0000, 1'b1, "R6 zero base addr 0", 1'b0);
    probe(4'b0111, 32'h0000_0FFC, 1'b1, "R6 zero base top", 1'b0);
    cfg_read(d); chk("R7 read of disabled", d, 32'h0);
  endtask

  task automatic t_we_low();
    logic [31:0] d;
    cfg_write(4'hF, 32'h9000_0000);
    @(negedge clk); cfg_be = 4'hF; cfg_wdata = 32'h1111_1111;
    @(negedge clk); cfg_be = 4'h0;
    cfg_read(d); chk("R11 we low ignored", d, 32'h9000_0000);
    probe(4'b0110, 32'h9000_0000, 1'b1, "R11 window unchanged", 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 hit low in reset", {31'b0, bar_hit}, 32'h0);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_sizing();
    t_byte_lanes();
    t_read_timing();
    t_window();
    t_cmds();
    t_mse_off();
    t_zero_base();
    t_we_low();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule